// File: doc/BRIEF.md
# Chained Latching Interrupt Bridge

This block is a secondary interrupt controller. It sits between a group of up to 32 event sources and a single input of a parent interrupt controller. Each source is watched for a rising edge. A rising edge sets a sticky bit in a cause register. The block then drives one chained output whenever any pending cause bit is also enabled in a mask register.

Software reaches the two registers over a small word-wide register bus. One request is made per cycle. Read data returns one cycle after the request, together with a valid strobe. Software handles an event in three steps. It reads the cause register, services the sources it finds, and then acknowledges each one by writing the cause register with a zero in that bit position and ones in all other positions. The block does not rank the sources or produce a vector; software does that.

The number of wired sources is a parameter with a default of 32. Bit positions above that count are not implemented.

Top module: `intc_chained_bridge`

## Requirements
- R1: The cause register sits at byte address 0x0 and the mask register at byte address 0x4. A read of any other address returns zero. A write to any other address changes no state.
- R2: A 0-to-1 transition of `src_in[i]` between two consecutive clock samples sets cause bit i at the second of those edges. A source that stays high sets its bit only once, so after an acknowledge the bit stays clear.
- R3: A write to the cause register clears every cause bit whose data bit is 0 and leaves every cause bit whose data bit is 1 unchanged. Cause bits never fall without such a write.
- R4: When a new rising edge on a source arrives in the same cycle as a write that would clear its cause bit, the bit ends up set.
- R5: A mask bit of 1 enables its source. `irq_out` is high exactly when some bit is set in both the cause and the mask registers. It follows a register update at the same clock edge. Writing 0 to the mask register forces `irq_out` low.
- R6: Cause bits latch events whatever the state of the mask. Enabling a source whose cause bit is already pending raises `irq_out` right after the mask write.
- R7: Reset clears the cause register, the mask register and the edge history. `irq_out` and `rd_valid` are low after reset.
- R8: `rd_valid` pulses high for exactly the one cycle after a read request, and is low after any other cycle. `rd_data` then holds the register value as it stood before the edge that accepted the request.
- R9: With `NSRC` below 32, mask and cause bits at positions NSRC and above read as zero and cannot be set by any write or source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A register request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while `rd_valid` is high |
| rd_valid | output | 1 | One-cycle strobe marking returned read data |
| src_in | input | NSRC | Event sources, sampled synchronously |
| irq_out | output | 1 | Chained request to the parent controller |

## Verification
The cause path is exercised with several source patterns:
- a single source rising while it is masked;
- a source held high across an acknowledge, which separates edge capture from level capture;
- two sources rising together;
- a rise on the top bit position;
- a rise that lands in the same cycle as the acknowledge of that bit, which shows whether set or clear wins.

Acknowledge words mix ones and zeros. This separates a clear-on-zero design from a clear-on-one or overwrite design. Unknown addresses are both read and written, to expose a loose address decode. A second instance with 12 sources has all-ones written to it and all its sources driven high, to show whether the unused upper bits stay at zero.

// File: rtl/intc_bridge_pkg.sv
package intc_bridge_pkg;

  localparam int BUS_W = 32;

  localparam logic [7:0] OFS_CAUSE = 8'h00;
  localparam logic [7:0] OFS_MASK  = 8'h04;

  // Bits that exist for a given source count.
  function automatic logic [BUS_W-1:0] live_bits(input int n);
    logic [BUS_W-1:0] m;
    for (int i = 0; i < BUS_W; i++) m[i] = (i < n);
    return m;
  endfunction

  // Acknowledge merge: zeros in wd clear, ones keep; new events always win.
  function automatic logic [BUS_W-1:0] ack_merge(
    input logic [BUS_W-1:0] cur,
    input logic [BUS_W-1:0] wd,
    input logic             we,
    input logic [BUS_W-1:0] evt
  );
    logic [BUS_W-1:0] kept;
    kept = we ? (cur & wd) : cur;
    return kept | evt;
  endfunction

  function automatic logic any_enabled(
    input logic [BUS_W-1:0] cause,
    input logic [BUS_W-1:0] mask
  );
    return |(cause & mask);
  endfunction

endpackage

// File: rtl/intc_edge_capture.sv
module intc_edge_capture
  import intc_bridge_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  output logic [BUS_W-1:0] rise_o
);

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    if (i < NSRC) begin : g_live
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_in[i];
      end
      assign rise_o[i] = src_in[i] & ~prev_q;
    end else begin : g_dead
      assign rise_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/intc_cause_bank.sv
module intc_cause_bank
  import intc_bridge_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] rise_i,
  input  logic             ack_we,
  input  logic [BUS_W-1:0] ack_data,
  output logic [BUS_W-1:0] cause_q
);

  localparam logic [BUS_W-1:0] LIVE = live_bits(NSRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= ack_merge(cause_q, ack_data, ack_we, rise_i) & LIVE;
  end

  // R2: a bit only rises when an edge was seen
  a_r2_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(rise_i)) == '0));

  // R3: without an acknowledge write no bit falls
  a_r3_no_fall_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> ((~cause_q & $past(cause_q)) == '0));

  // R4: every captured edge is set afterwards, clearing write or not
  a_r4_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((cause_q & $past(rise_i)) == $past(rise_i)));

endmodule

// File: rtl/intc_reg_port.sv
module intc_reg_port
  import intc_bridge_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [BUS_W-1:0]  cause_q,
  output logic [BUS_W-1:0]  mask_q,
  output logic              ack_we,
  output logic [BUS_W-1:0]  ack_data,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid
);

  localparam logic [BUS_W-1:0] LIVE = live_bits(NSRC);

  logic hit_cause, hit_mask, rd_req, mask_we;

  assign hit_cause = (req_addr == OFS_CAUSE[ADDR_W-1:0]);
  assign hit_mask  = (req_addr == OFS_MASK[ADDR_W-1:0]);
  assign rd_req    = req_valid & ~req_write;
  assign mask_we   = req_valid & req_write & hit_mask;
  assign ack_we    = req_valid & req_write & hit_cause;
  assign ack_data  = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= req_wdata & LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        if (hit_cause)     rd_data <= cause_q;
        else if (hit_mask) rd_data <= mask_q;
        else               rd_data <= '0;
      end
    end
  end

  // R8: strobe follows a read request by exactly one cycle
  a_r8_strobe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r8_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

endmodule

// File: rtl/intc_chained_bridge.sv
module intc_chained_bridge
  import intc_bridge_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_out
);

  logic [BUS_W-1:0] rise_w, cause_w, mask_w, ack_data_w;
  logic             ack_we_w;

  intc_edge_capture #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .rise_o(rise_w)
  );

  intc_cause_bank #(.NSRC(NSRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
    .ack_we(ack_we_w), .ack_data(ack_data_w), .cause_q(cause_w)
  );

  intc_reg_port #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cause_q(cause_w), .mask_q(mask_w),
    .ack_we(ack_we_w), .ack_data(ack_data_w),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign irq_out = any_enabled(cause_w, mask_w);

  // R5: an all-zero mask keeps the chained line low
  a_r5_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> !irq_out);

  // R6: a pending cause that becomes enabled raises the line
  a_r6_unmask_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cause_w) != '0 && $stable(cause_w) && (mask_w & cause_w) != '0) |-> irq_out);

endmodule

// File: tb/test_intc_chained_bridge.sv
module test_intc_chained_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] src = '0;
  logic [31:0] rd_data, n_rd_data;
  logic        rd_valid, n_rd_valid, irq_out, n_irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  intc_chained_bridge i_intc_chained_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .src_in(src), .irq_out(irq_out)
  );

  // Second instance with 12 sources, sharing the bus
  intc_chained_bridge #(.NSRC(12)) i_intc_chained_bridge_narrow (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(n_rd_data),
    .rd_valid(n_rd_valid), .src_in(src[11:0]), .irq_out(n_irq_out)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // op: 0 idle, 1 write, 2 read. Drive at negedge, check at the following negedge.
  task automatic step(input logic [1:0] op, input logic [3:0] a,
                      input logic [31:0] wd, input logic [31:0] s);
    req_valid = (op != 2'd0);
    req_write = (op == 2'd1);
    req_addr  = a;
    req_wdata = wd;
    src       = s;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] wd;
    logic [31:0] src;
    logic        irq;
    logic [31:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VECS [19] = '{
    '{2'd2, 4'h0, 32'h0,        32'h0,        1'b0, 32'h0,        4'd7}, // R7 cause empty
    '{2'd0, 4'h0, 32'h0,        32'h5,        1'b0, 32'h0,        4'd6}, // R6 latch while masked
    '{2'd2, 4'h0, 32'h0,        32'h5,        1'b0, 32'h5,        4'd2}, // R2 two edges
    '{2'd1, 4'h4, 32'h4,        32'h5,        1'b1, 32'h0,        4'd6}, // R6 unmask fires
    '{2'd1, 4'h0, 32'hFFFFFFFB, 32'h5,        1'b0, 32'h0,        4'd3}, // R3 clear bit 2
    '{2'd2, 4'h0, 32'h0,        32'h5,        1'b0, 32'h1,        4'd2}, // R2 held level no reset
    '{2'd0, 4'h0, 32'h0,        32'h0,        1'b0, 32'h0,        4'd3}, // R3 no fall
    '{2'd1, 4'h0, 32'hFFFFFFFE, 32'h1,        1'b0, 32'h0,        4'd4}, // R4 edge with clear
    '{2'd2, 4'h0, 32'h0,        32'h1,        1'b0, 32'h1,        4'd4}, // R4 bit kept
    '{2'd1, 4'h4, 32'h1,        32'h1,        1'b1, 32'h0,        4'd5}, // R5 enabled pending
    '{2'd1, 4'h0, 32'h0,        32'h1,        1'b0, 32'h0,        4'd3}, // R3 clear all
    '{2'd2, 4'h4, 32'h0,        32'h1,        1'b0, 32'h1,        4'd1}, // R1 mask at 0x4
    '{2'd2, 4'h8, 32'h0,        32'h1,        1'b0, 32'h0,        4'd1}, // R1 unknown reads 0
    '{2'd1, 4'h8, 32'hFFFFFFFF, 32'h1,        1'b0, 32'h0,        4'd1}, // R1 unknown write
    '{2'd2, 4'h4, 32'h0,        32'h1,        1'b0, 32'h1,        4'd1}, // R1 mask untouched
    '{2'd0, 4'h0, 32'h0,        32'h80000001, 1'b0, 32'h0,        4'd2}, // R2 top bit edge
    '{2'd1, 4'h4, 32'h80000000, 32'h80000001, 1'b1, 32'h0,        4'd5}, // R5 top bit enabled
    '{2'd2, 4'h0, 32'h0,        32'h80000001, 1'b1, 32'h80000000, 4'd2}, // R2 top bit read
    '{2'd1, 4'h4, 32'h0,        32'h80000001, 1'b0, 32'h0,        4'd5}  // R5 zero mask
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "irq after reset", {31'b0, irq_out}, 32'h0);
    check("R7", "rd_valid after reset", {31'b0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 19; k++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[k].rq);
      step(VECS[k].op, VECS[k].addr, VECS[k].wd, VECS[k].src);
      check(tag, $sformatf("vec %0d irq", k), {31'b0, irq_out}, {31'b0, VECS[k].irq});
      check("R8", $sformatf("vec %0d rd_valid", k), {31'b0, rd_valid},
            {31'b0, VECS[k].op == 2'd2});
      if (VECS[k].op == 2'd2)
        check(tag, $sformatf("vec %0d rd_data", k), rd_data, VECS[k].rd);
    end

    // R8: strobe lasts one cycle only
    step(2'd0, 4'h0, 32'h0, 32'h80000001);
    check("R8", "strobe drops", {31'b0, rd_valid}, 32'h0);

    // R7: reset clears pending state
    step(2'd1, 4'h4, 32'hFFFFFFFF, 32'h80000001);
    check("R5", "irq before reset", {31'b0, irq_out}, 32'h1);
    src = '0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R7", "irq in reset", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step(2'd2, 4'h4, 32'h0, 32'h0);
    check("R7", "mask after reset", rd_data, 32'h0);

    // R9: narrow instance upper bits
    step(2'd1, 4'h4, 32'hFFFFFFFF, 32'h0);
    step(2'd1, 4'h0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R5", "wide irq all sources", {31'b0, irq_out}, 32'h1);
    step(2'd2, 4'h4, 32'h0, 32'hFFFFFFFF);
    check("R9", "narrow mask", n_rd_data, 32'h00000FFF);
    step(2'd2, 4'h0, 32'h0, 32'hFFFFFFFF);
    check("R9", "narrow cause", n_rd_data, 32'h00000FFF);
    check("R2", "wide cause all", rd_data, 32'hFFFFFFFF);
    check("R9", "narrow irq", {31'b0, n_irq_out}, 32'h1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule